// File: doc/BRIEF.md
# Frame-Buffer Pixel Unpacker with Colour Table

This block sits between a frame-buffer word stream and an LCD panel pipeline. It accepts 32-bit words through a valid/ready input and emits one 24-bit RGB pixel per accepted output beat through a valid/ready output. Low-depth pixels of 1, 2, 4 or 8 bits are treated as indices into a 256-entry colour table. Direct-colour pixels skip the table: 16-bit RGB565, 24-bit with one pixel per word, or 24-bit packed so that four pixels fill three words.

The pixel format and the output colour depth are sampled only on a frame-start strobe. The strobe also flushes any partly emitted word and restarts the packed-24 byte phase, so a new frame always begins clean. The colour table is loaded through a write port that is meant to be used while no pixels are flowing. Output depths below 24 bits keep the upper bits of each channel and clear the lower bits.

Top module: `lcd_pix_unpack`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1. The active format is 1-bit indexed and the output depth is 24 bits until the first frame_start.
- R2: Formats 0, 1, 2 and 3 select 1, 2, 4 and 8 bits per pixel. Each word yields 32, 16, 8 or 4 pixels, taken from bit 0 upward. The pixel value indexes the colour table, and the output is that table entry.
- R3: Format 4 holds two RGB565 pixels per word, low halfword first (R in bits 15:11, G in 10:5, B in 4:0). Each channel is widened to 8 bits by copying its top bits below it. The output is {R,G,B}, with R in bits 23:16.
- R4: Formats 6 and 7 take one pixel per word from bits 23:0. Bits 31:24 are ignored.
- R5: Format 5 packs four 24-bit pixels into three words, little-endian. Pixel 0 is word0[23:0]. Pixel 1 is {word1[15:0], word0[31:24]}. Pixel 2 is {word2[7:0], word1[31:16]}. Pixel 3 is word2[31:8].
- R6: Output depth code 0 keeps all bits. Code 1 keeps 6/6/6 bits per channel, code 2 keeps 5/6/5 and code 3 keeps 4/4/4. In every case the upper bits are kept and the rest are cleared.
- R7: A new word is taken only in the cycle its predecessor's last pixel is accepted, or while no word is held. Under continuous flow there is no idle cycle between words. A pixel held while out_ready is low stays stable, and no input is taken meanwhile.
- R8: In a frame_start cycle, in_ready and out_valid are 0, any held word is discarded, the format and depth are loaded, and the packed-24 phase returns to pixel 0.
- R9: Changes on cfg_mode and cfg_depth without frame_start have no effect on the output.
- R10: An entry written through pal_we, pal_addr and pal_wdata is used by every later lookup of that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame boundary strobe; loads format and depth |
| cfg_mode | input | 3 | Pixel format code (0-3 indexed, 4 RGB565, 5 packed 24, 6/7 unpacked 24) |
| cfg_depth | input | 2 | Output depth code (0:24, 1:18, 2:16, 3:12) |
| in_data | input | 32 | Frame-buffer word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word taken this cycle when valid |
| pal_we | input | 1 | Colour table write enable |
| pal_addr | input | 8 | Colour table index |
| pal_wdata | input | 24 | Colour table entry {R,G,B} |
| out_rgb | output | 24 | Pixel {R,G,B} |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Downstream accepts pixel |

## Verification
Two events can fall in the same cycle: frame_start, and a word arriving at the input while an earlier word is still held and stalled. The bench first holds one word by keeping out_ready low. It then raises frame_start with a word of a new format already presented. That cycle must show in_ready and out_valid both low. Afterwards the held word must be gone, and the presented word must come out decoded in the new format. The bench also lets the last-pixel acceptance and the next word load share a cycle, and checks that no bubble appears in the stream.

// File: rtl/lcd_pix_unpack.sv
module lcd_pix_unpack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_start,
  input  logic [2:0]  cfg_mode,
  input  logic [1:0]  cfg_depth,
  input  logic [31:0] in_data,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        pal_we,
  input  logic [7:0]  pal_addr,
  input  logic [23:0] pal_wdata,
  output logic [23:0] out_rgb,
  output logic        out_valid,
  input  logic        out_ready
);
  localparam int PAL_N = 256;

  logic [2:0]  mode_q;
  logic [1:0]  dep_q;
  logic [31:0] word_q;
  logic        have;
  logic [4:0]  idx;
  logic [1:0]  ph;
  logic [15:0] carry;
  logic [23:0] pal [PAL_N];

  logic [4:0]  last_idx;
  logic [4:0]  sh;
  logic [7:0]  pmask, pidx;
  logic [15:0] hw;
  logic [23:0] raw, dmask;
  logic        last, fire_in, fire_out;

  always_comb
    case (mode_q)
      3'd0: last_idx = 5'd31;
      3'd1: last_idx = 5'd15;
      3'd2: last_idx = 5'd7;
      3'd3: last_idx = 5'd3;
      3'd4: last_idx = 5'd1;
      3'd5: last_idx = (ph == 2'd2) ? 5'd1 : 5'd0;
      default: last_idx = 5'd0;
    endcase

  assign last = (idx == last_idx);
  assign sh   = idx << mode_q[1:0];

  always_comb
    case (mode_q[1:0])
      2'd0: pmask = 8'h01;
      2'd1: pmask = 8'h03;
      2'd2: pmask = 8'h0f;
      default: pmask = 8'hff;
    endcase

  assign pidx = 8'(word_q >> sh) & pmask;
  assign hw   = idx[0] ? word_q[31:16] : word_q[15:0];

  always_comb
    case (mode_q)
      3'd0, 3'd1, 3'd2, 3'd3: raw = pal[pidx];
      3'd4: raw = {hw[15:11], hw[15:13], hw[10:5], hw[10:9], hw[4:0], hw[4:2]};
      3'd5:
        case (ph)
          2'd0: raw = word_q[23:0];
          2'd1: raw = {word_q[15:0], carry[7:0]};
          default: raw = idx[0] ? word_q[31:8] : {word_q[7:0], carry};
        endcase
      default: raw = word_q[23:0];
    endcase

  always_comb
    case (dep_q)
      2'd0: dmask = 24'hffffff;
      2'd1: dmask = 24'hfcfcfc;
      2'd2: dmask = 24'hf8fcf8;
      default: dmask = 24'hf0f0f0;
    endcase

  assign out_rgb   = raw & dmask;
  assign out_valid = have & ~frame_start;
  assign in_ready  = ~frame_start & (~have | (out_ready & last));
  assign fire_out  = out_valid & out_ready;
  assign fire_in   = in_valid & in_ready;

  always_ff @(posedge clk)
    if (pal_we) pal[pal_addr] <= pal_wdata;

  always_ff @(posedge clk)
    if (!rst_n) begin
      mode_q <= 3'd0;
      dep_q  <= 2'd0;
      word_q <= 32'd0;
      have   <= 1'b0;
      idx    <= 5'd0;
      ph     <= 2'd0;
      carry  <= 16'd0;
    end else if (frame_start) begin
      mode_q <= cfg_mode;
      dep_q  <= cfg_depth;
      have   <= 1'b0;
      idx    <= 5'd0;
      ph     <= 2'd0;
      carry  <= 16'd0;
    end else begin
      if (fire_out) begin
        if (last) begin
          have <= 1'b0;
          idx  <= 5'd0;
          if (mode_q == 3'd5) begin
            ph <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;
            if (ph == 2'd0)      carry <= {8'd0, word_q[31:24]};
            else if (ph == 2'd1) carry <= word_q[31:16];
          end
        end else begin
          idx <= idx + 5'd1;
        end
      end
      if (fire_in) begin
        word_q <= in_data;
        have   <= 1'b1;
        idx    <= 5'd0;
      end
    end
endmodule

// File: rtl/lcd_pix_unpack_chk.sv
module lcd_pix_unpack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_start,
  input logic        in_valid,
  input logic        in_ready,
  input logic        pal_we,
  input logic [23:0] out_rgb,
  input logic        out_valid,
  input logic        out_ready
);
  assert_fs_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (!in_ready && !out_valid));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !frame_start && !pal_we) |=>
      (frame_start || (out_valid && $stable(out_rgb))));

  assert_stall_no_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_load_shows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (frame_start || out_valid));

  assert_empty_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !frame_start) |-> in_ready);
endmodule

bind lcd_pix_unpack lcd_pix_unpack_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
  .in_ready(in_ready), .pal_we(pal_we), .out_rgb(out_rgb),
  .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/sim_lcd_pix_unpack.sv
module sim_lcd_pix_unpack;
  logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0;
  logic [2:0] cfg_mode = 3'd0;
  logic [1:0] cfg_depth = 2'd0;
  logic [31:0] in_data = 32'd0;
  logic in_valid = 1'b0, in_ready;
  logic pal_we = 1'b0;
  logic [7:0] pal_addr = 8'd0;
  logic [23:0] pal_wdata = 24'd0;
  logic [23:0] out_rgb;
  logic out_valid, out_ready = 1'b0;

  always #10 clk = ~clk;

  lcd_pix_unpack u0 (.*);

  int checks = 0, fails = 0;
  logic [23:0] pal_m [256];
  logic [23:0] expq [$];
  logic [31:0] wq [$];
  int b_ph;
  logic [15:0] b_carry;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] dmask(input int dep);
    case (dep)
      0: return 24'hffffff;
      1: return 24'hfcfcfc;
      2: return 24'hf8fcf8;
      default: return 24'hf0f0f0;
    endcase
  endfunction

  function automatic string tag_of(input int mode, input int dep);
    if (dep != 0) return "R6";
    if (mode < 4) return "R2";
    if (mode == 4) return "R3";
    if (mode == 5) return "R5";
    return "R4";
  endfunction

  task automatic model_word(input int mode, input int dep, input logic [31:0] w);
    logic [23:0] m;
    m = dmask(dep);
    if (mode < 4) begin
      int bpp;
      bpp = 1 << mode;
      for (int i = 0; i < 32 / bpp; i++)
        expq.push_back(pal_m[8'((w >> (i * bpp)) & ((32'd1 << bpp) - 1))] & m);
    end else if (mode == 4) begin
      for (int i = 0; i < 2; i++) begin
        logic [15:0] h;
        logic [7:0] r, g, b;
        h = 16'(w >> (16 * i));
        r = {h[15:11], 3'b0}; r = r | (r >> 5);
        g = {h[10:5], 2'b0};  g = g | (g >> 6);
        b = {h[4:0], 3'b0};   b = b | (b >> 5);
        expq.push_back({r, g, b} & m);
      end
    end else if (mode == 5) begin
      case (b_ph)
        0: begin expq.push_back(w[23:0] & m); b_carry = {8'h00, w[31:24]}; end
        1: begin expq.push_back({w[15:0], b_carry[7:0]} & m); b_carry = w[31:16]; end
        default: begin
          expq.push_back({w[7:0], b_carry} & m);
          expq.push_back(w[31:8] & m);
        end
      endcase
      b_ph = (b_ph + 1) % 3;
    end else begin
      expq.push_back(w[23:0] & m);
    end
  endtask

  task automatic pal_write(input logic [7:0] a, input logic [23:0] d);
    @(negedge clk);
    pal_we = 1'b1; pal_addr = a; pal_wdata = d; pal_m[a] = d;
    @(negedge clk);
    pal_we = 1'b0;
  endtask

  task automatic run_frame(input int mode, input int dep, input int nw, input int bp,
                           input int ivp, input bit do_fs, input bit scramble, input bit nobp);
    logic [23:0] prev = 24'd0;
    bit stall = 0, started = 0;
    int gaps = 0, sent = 0, guard = 0;
    string tg;
    tg = scramble ? "R9" : tag_of(mode, dep);
    if (do_fs) begin
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b0;
      cfg_mode = 3'(mode); cfg_depth = 2'(dep); frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      b_ph = 0; b_carry = 16'd0;
    end else @(negedge clk);
    if (scramble) begin cfg_mode = ~3'(mode); cfg_depth = ~2'(dep); end
    while (wq.size() < nw) wq.push_back($urandom);
    for (int i = 0; i < nw; i++) model_word(mode, dep, wq[i]);
    while ((sent < nw || expq.size() > 0) && guard < 20000) begin
      guard++;
      in_valid = (sent < nw) && (($urandom % 100) < ivp);
      in_data = (sent < nw) ? wq[sent] : 32'd0;
      out_ready = ($urandom % 100) >= bp;
      #5;
      if (stall) chk(out_valid && out_rgb == prev, "R7 stalled pixel held", {7'd0, out_valid, out_rgb}, {8'h01, prev});
      if (out_valid && out_ready) begin
        started = 1;
        if (expq.size() == 0) chk(0, "R7 extra pixel", out_rgb, 0);
        else begin
          logic [23:0] e;
          e = expq.pop_front();
          chk(out_rgb == e, {tg, " pixel"}, out_rgb, e);
        end
      end else if (nobp && started && expq.size() > 0 && !out_valid) gaps++;
      stall = out_valid && !out_ready;
      prev = out_rgb;
      if (in_valid && in_ready) sent++;
      @(negedge clk);
    end
    in_valid = 1'b0; out_ready = 1'b0;
    if (guard >= 20000) chk(0, "R7 frame did not drain", expq.size(), 0);
    if (nobp) chk(gaps == 0, "R7 no bubble between words", gaps, 0);
    expq.delete();
    wq.delete();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog expired", 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      pal_we = 1'b1; pal_addr = 8'(a); pal_wdata = 24'($urandom); pal_m[a] = pal_wdata;
    end
    @(negedge clk); pal_we = 1'b0;
    rst_n = 1'b1;
    #5;
    chk(!out_valid && in_ready, "R1 reset outputs", {out_valid, in_ready}, 2'b01);

    // R1: default format is 1 bpp indexed, depth 24
    b_ph = 0; b_carry = 16'd0;
    run_frame(0, 0, 2, 0, 100, 0, 0, 0);

    for (int m = 0; m < 8; m++) run_frame(m, 0, 6, 0, 100, 1, 0, 1);
    for (int d = 1; d < 4; d++) begin
      run_frame(6, d, 4, 20, 80, 1, 0, 0);
      run_frame(4, d, 4, 20, 80, 1, 0, 0);
      run_frame(3, d, 3, 20, 80, 1, 0, 0);
    end

    // R4: top byte ignored
    wq.push_back(32'hff123456); wq.push_back(32'h00123456);
    run_frame(6, 0, 2, 0, 100, 1, 0, 0);

    // R9: config inputs moved mid-frame
    run_frame(2, 1, 5, 30, 70, 1, 1, 0);

    // R5/R8: packed phase restarts after an uneven frame
    run_frame(5, 0, 4, 30, 70, 1, 0, 0);
    wq.push_back(32'h44332211); wq.push_back(32'h88776655); wq.push_back(32'hccbbaa99);
    run_frame(5, 0, 3, 0, 100, 1, 0, 0);

    // R10: rewriting a table entry changes later lookups
    pal_write(8'd5, 24'h123456);
    wq.push_back(32'h05050505);
    run_frame(3, 0, 1, 0, 100, 1, 0, 0);
    pal_write(8'd5, 24'hfedcba);
    wq.push_back(32'h05050505);
    run_frame(3, 0, 1, 0, 100, 1, 0, 0);

    // R8: frame_start together with a held word and a presented word
    @(negedge clk);
    cfg_mode = 3'd6; cfg_depth = 2'd0; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0; in_valid = 1'b1; in_data = 32'h00abcdef; out_ready = 1'b0;
    #5;
    chk(in_ready, "R8 empty before hold", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    #5;
    chk(out_valid && out_rgb == 24'habcdef, "R4 held word shown", {7'd0, out_valid, out_rgb}, 32'h01abcdef);
    @(negedge clk);
    frame_start = 1'b1; cfg_mode = 3'd4; in_valid = 1'b1; in_data = 32'hf81f07e0;
    #5;
    chk(!in_ready && !out_valid, "R8 strobe blocks both sides", {in_ready, out_valid}, 0);
    @(negedge clk);
    frame_start = 1'b0; in_valid = 1'b0;
    wq.push_back(32'hf81f07e0);
    run_frame(4, 0, 1, 0, 100, 0, 0, 0);

    for (int f = 0; f < 30; f++)
      run_frame($urandom % 8, $urandom % 4, 1 + $urandom % 10, $urandom % 60,
                40 + $urandom % 61, 1, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule